// File: doc/BRIEF.md
# Parallel LFSR Noise Generator

This block produces a word of pseudo-random noise bits for audio synthesis. Its core is a Fibonacci linear feedback shift register that does not shift once per update. On each accepted sample strobe it jumps forward by as many single shifts as the output word is wide. The multi-step next state comes from an unrolled chain of XOR stages, so every update delivers a full word of fresh noise bits in one clock instead of one serial bit.

The feedback polynomial is chosen at elaboration. One preset is a 23-stage register with feedback from stages 23 and 18. A second preset is a 31-stage register with feedback from stages 31 and 28. A third setting takes a user-given length and tap. The word width may be narrower than the register, for example a 16-bit word from the 31-stage register. A seed can be loaded at any time. The all-zero lock-up state cannot be entered.

The host pulses the strobe once per output sample. That rate can be a few tens of kHz, several hundred kHz, or one strobe every clock. One cycle later it collects the word, which is marked by a one-cycle valid pulse.

Top module: `lfsr_noise_gen`

## Requirements
- R1: After synchronous reset the register holds the default seed (parameter, non-zero, default 1), the noise word is zero and the valid flag is low.
- R2: One accepted strobe advances the register by exactly OUT_W single shifts. A single shift moves every bit one place toward the MSB, and the XOR of bit LEN-1 and bit TAP-1 (bit 0 is the LSB) enters bit 0.
- R3: The noise word is the last OUT_W feedback bits produced by those shifts. The first produced bit is in the MSB and the last in bit 0, so the word equals the low OUT_W bits of the new register state.
- R4: The valid flag is high for exactly the cycle after each accepted strobe and low otherwise. Strobes on consecutive cycles each yield a word on consecutive cycles.
- R5: In a cycle with neither strobe nor seed load, the register and the noise word keep their values.
- R6: A seed load writes the seed into the register and leaves the noise word unchanged. An all-zero seed is replaced by the default seed.
- R7: When a seed load and a strobe coincide, the load wins: no shift happens and no valid pulse follows.
- R8: The register never holds the all-zero state.
- R9: POLY_SEL = 0 selects 23 stages with tap 18. POLY_SEL = 1 selects 31 stages with tap 28. POLY_SEL = 2 uses CUST_LEN and CUST_TAP. WORD_W = 0 makes the word as wide as the register.
- R10: With a primitive polynomial and OUT_W coprime to 2^LEN-1, the register passes through every non-zero state exactly once in 2^LEN-1 strobes before it returns to its seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleEn | input | 1 | One-cycle strobe requesting a new noise word |
| seedLoad | input | 1 | Load seedIn into the register |
| seedIn | input | LEN | Seed value; zero selects the default seed |
| noiseWord | output | OUT_W | Latest noise word |
| noiseValid | output | 1 | High for one cycle after each accepted strobe |

## Verification
Several properties are checked on every cycle:
- the register is never zero;
- idle cycles hold both the register and the word;
- a load writes the seed, or the default seed for a zero seed, and leaves the word alone;
- a load blocks the valid pulse;
- a valid word equals the low part of the register;
- when the word is narrower than the register, the upper stages carry the shifted old state.

Only the bench scenarios can show that the XOR look-ahead equals many single shifts of a serial model, for both presets and for a narrow word. Only the bench can show the full-period property, through an exhaustive walk of a 7-stage register over all 127 non-zero states.

// File: rtl/lfsr_noise_pkg.sv
package lfsr_noise_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadSeed;
    logic advance;
  } lfsrStrobe_t;

  function automatic int regLen(input int sel, input int custLen);
    case (sel)
      0:       return 23;
      1:       return 31;
      default: return custLen;
    endcase
  endfunction

  function automatic int regTap(input int sel, input int custTap);
    case (sel)
      0:       return 18;
      1:       return 28;
      default: return custTap;
    endcase
  endfunction

  // Word width: 0 or out-of-range means full register width
  function automatic int wordWidth(input int req, input int len);
    return (req <= 0 || req > len) ? len : req;
  endfunction

endpackage

// File: rtl/lfsr_noise_jump.sv
// Combinational look-ahead: STEPS single shifts unrolled into XOR stages.
module lfsr_noise_jump #(
  parameter int LEN   = 23,
  parameter int TAP   = 18,
  parameter int STEPS = 23
) (
  input  logic [LEN-1:0] stateIn,
  output logic [LEN-1:0] stateOut
);

  logic [LEN-1:0] chain [STEPS+1];

  assign chain[0] = stateIn;

  for (genvar g = 0; g < STEPS; g++) begin : g_shift
    assign chain[g+1] = {chain[g][LEN-2:0], chain[g][LEN-1] ^ chain[g][TAP-1]};
  end

  assign stateOut = chain[STEPS];

endmodule

// File: rtl/lfsr_noise_ctrl.sv
module lfsr_noise_ctrl
  import lfsr_noise_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sampleEn,
  input  logic        seedLoad,
  output lfsrStrobe_t strobe,
  output logic        noiseValid
);

  // A load always wins over a sample strobe
  always_comb begin
    strobe.loadSeed = seedLoad;
    strobe.advance  = sampleEn & ~seedLoad;
  end

  always_ff @(posedge clk) begin
    if (rst) noiseValid <= 1'b0;
    else     noiseValid <= strobe.advance;
  end

  AST_LOAD_BLOCKS_VALID: assert property (@(posedge clk) disable iff (rst)
    seedLoad |=> !noiseValid); // R7

endmodule

// File: rtl/lfsr_noise_datapath.sv
module lfsr_noise_datapath
  import lfsr_noise_pkg::*;
#(
  parameter int             LEN      = 23,
  parameter int             TAP      = 18,
  parameter int             OUT_W    = 23,
  parameter logic [LEN-1:0] SEED_DEF = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  lfsrStrobe_t       strobe,
  input  logic [LEN-1:0]    seedIn,
  output logic [OUT_W-1:0]  noiseWord,
  output logic [LEN-1:0]    stateQ
);

  logic [LEN-1:0] jumped;
  logic [LEN-1:0] loadVal;

  lfsr_noise_jump #(
    .LEN  (LEN),
    .TAP  (TAP),
    .STEPS(OUT_W)
  ) i_jump (
    .stateIn (stateQ),
    .stateOut(jumped)
  );

  // Zero seed would lock the register; substitute the default
  assign loadVal = (seedIn == '0) ? SEED_DEF : seedIn;

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ    <= SEED_DEF;
      noiseWord <= '0;
    end else if (strobe.loadSeed) begin
      stateQ    <= loadVal;
    end else if (strobe.advance) begin
      stateQ    <= jumped;
      noiseWord <= jumped[OUT_W-1:0];
    end
  end

  AST_STATE_NONZERO: assert property (@(posedge clk) disable iff (rst)
    stateQ != '0); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!strobe.advance && !strobe.loadSeed) |=> ($stable(stateQ) && $stable(noiseWord))); // R5

  AST_LOAD_SEED: assert property (@(posedge clk) disable iff (rst)
    (strobe.loadSeed && seedIn != '0) |=> stateQ == $past(seedIn)); // R6

  AST_LOAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (strobe.loadSeed && seedIn == '0) |=> stateQ == SEED_DEF); // R6

  AST_LOAD_KEEPS_WORD: assert property (@(posedge clk) disable iff (rst)
    strobe.loadSeed |=> $stable(noiseWord)); // R6

  if (OUT_W < LEN) begin : g_carry_chk
    AST_SHIFT_CARRY: assert property (@(posedge clk) disable iff (rst)
      strobe.advance |=> stateQ[LEN-1:OUT_W] == $past(stateQ[LEN-1-OUT_W:0])); // R2
  end

endmodule

// File: rtl/lfsr_noise_gen.sv
module lfsr_noise_gen
  import lfsr_noise_pkg::*;
#(
  parameter int          POLY_SEL     = 0,
  parameter int          CUST_LEN     = 7,
  parameter int          CUST_TAP     = 6,
  parameter int          WORD_W       = 0,
  parameter logic [63:0] DEFAULT_SEED = 64'h1,
  localparam int         LEN          = regLen(POLY_SEL, CUST_LEN),
  localparam int         OUT_W        = wordWidth(WORD_W, LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sampleEn,
  input  logic             seedLoad,
  input  logic [LEN-1:0]   seedIn,
  output logic [OUT_W-1:0] noiseWord,
  output logic             noiseValid
);

  localparam int             TAP      = regTap(POLY_SEL, CUST_TAP);
  localparam logic [LEN-1:0] SEED_DEF = DEFAULT_SEED[LEN-1:0];

  lfsrStrobe_t    strobe;
  logic [LEN-1:0] stateQ;

  lfsr_noise_ctrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .sampleEn  (sampleEn),
    .seedLoad  (seedLoad),
    .strobe    (strobe),
    .noiseValid(noiseValid)
  );

  lfsr_noise_datapath #(
    .LEN     (LEN),
    .TAP     (TAP),
    .OUT_W   (OUT_W),
    .SEED_DEF(SEED_DEF)
  ) i_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .seedIn   (seedIn),
    .noiseWord(noiseWord),
    .stateQ   (stateQ)
  );

  AST_WORD_TRACKS_STATE: assert property (@(posedge clk) disable iff (rst)
    noiseValid |-> noiseWord == stateQ[OUT_W-1:0]); // R3

endmodule

// File: tb/test_lfsr_noise_gen.sv
module test_lfsr_noise_gen;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;   // 50 MHz

  logic        en   [3];
  logic        ld   [3];
  logic [63:0] seedV[3];
  logic [63:0] wordObs[3];
  logic        vld  [3];

  logic [22:0] wordA;
  logic [15:0] wordB;
  logic [6:0]  wordC;

  // Unit 0: 23/18 full word, unit 1: 31/28 16-bit word, unit 2: 7/6 small
  lfsr_noise_gen #(.POLY_SEL(0)) i_lfsr_noise_gen (
    .clk(clk), .rst(rst), .sampleEn(en[0]), .seedLoad(ld[0]),
    .seedIn(seedV[0][22:0]), .noiseWord(wordA), .noiseValid(vld[0]));

  lfsr_noise_gen #(.POLY_SEL(1), .WORD_W(16)) i_lfsr_noise_gen_wide (
    .clk(clk), .rst(rst), .sampleEn(en[1]), .seedLoad(ld[1]),
    .seedIn(seedV[1][30:0]), .noiseWord(wordB), .noiseValid(vld[1]));

  lfsr_noise_gen #(.POLY_SEL(2), .CUST_LEN(7), .CUST_TAP(6)) i_lfsr_noise_gen_small (
    .clk(clk), .rst(rst), .sampleEn(en[2]), .seedLoad(ld[2]),
    .seedIn(seedV[2][6:0]), .noiseWord(wordC), .noiseValid(vld[2]));

  assign wordObs[0] = 64'(wordA);
  assign wordObs[1] = 64'(wordB);
  assign wordObs[2] = 64'(wordC);

  int lenU [3] = '{23, 31, 7};
  int tapU [3] = '{18, 28, 6};
  int outU [3] = '{23, 16, 7};

  logic [63:0] mdl[3];
  logic [63:0] lastWord[3];

  int total = 0;
  int bad   = 0;
  bit timedOut = 1'b0;

  function automatic logic [63:0] maskOf(input int w);
    return (w >= 64) ? '1 : ((64'h1 << w) - 64'h1);
  endfunction

  // Bit-serial reference: k single shifts
  function automatic logic [63:0] serialJump(input logic [63:0] s, input int len,
                                             input int tap, input int k);
    logic [63:0] v = s;
    for (int i = 0; i < k; i++) begin
      logic fb = v[len-1] ^ v[tap-1];
      v = ((v << 1) | 64'(fb)) & maskOf(len);
    end
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One accepted strobe, then check word and valid (R2 R3 R4)
  task automatic doStep(input int u);
    @(negedge clk); en[u] = 1'b1;
    @(negedge clk); en[u] = 1'b0;
    mdl[u] = serialJump(mdl[u], lenU[u], tapU[u], outU[u]);
    check(vld[u] == 1'b1, "R4 valid after strobe", 64'(vld[u]), 64'h1);
    check(wordObs[u] == (mdl[u] & maskOf(outU[u])), "R2/R3 word vs serial model",
          wordObs[u], mdl[u] & maskOf(outU[u]));
    check(wordObs[u] != 0 || outU[u] < lenU[u], "R8 nonzero word", wordObs[u], 64'h1);
    lastWord[u] = wordObs[u];
  endtask

  // Back-to-back strobes (R4)
  task automatic burst(input int u, input int n);
    @(negedge clk); en[u] = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == n - 1) en[u] = 1'b0;
      mdl[u] = serialJump(mdl[u], lenU[u], tapU[u], outU[u]);
      check(vld[u] == 1'b1, "R4 valid in burst", 64'(vld[u]), 64'h1);
      check(wordObs[u] == (mdl[u] & maskOf(outU[u])), "R4 burst word",
            wordObs[u], mdl[u] & maskOf(outU[u]));
    end
    lastWord[u] = wordObs[u];
  endtask

  // Idle cycles: no valid, word held (R5)
  task automatic idle(input int u, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(vld[u] == 1'b0, "R5 R4 valid low when idle", 64'(vld[u]), 64'h0);
      check(wordObs[u] == lastWord[u], "R5 word held", wordObs[u], lastWord[u]);
    end
  endtask

  // Seed load, optionally with a coinciding strobe (R6 R7)
  task automatic doLoad(input int u, input logic [63:0] s, input bit withEn);
    @(negedge clk); ld[u] = 1'b1; en[u] = withEn; seedV[u] = s;
    @(negedge clk); ld[u] = 1'b0; en[u] = 1'b0;
    check(vld[u] == 1'b0, withEn ? "R7 no valid on load+strobe" : "R6 no valid on load",
          64'(vld[u]), 64'h0);
    check(wordObs[u] == lastWord[u], "R6 word unchanged by load", wordObs[u], lastWord[u]);
    mdl[u] = ((s & maskOf(lenU[u])) == 0) ? 64'h1 : (s & maskOf(lenU[u]));
  endtask

  task automatic runTests;
    bit seen[128];
    int distinct;
    for (int u = 0; u < 3; u++) begin
      en[u] = 1'b0; ld[u] = 1'b0; seedV[u] = '0;
      mdl[u] = 64'h1; lastWord[u] = '0;
    end
    rst = 1'b1;
    repeat (3) @(negedge clk);
    for (int u = 0; u < 3; u++) begin
      check(wordObs[u] == 0, "R1 word zero in reset", wordObs[u], 64'h0);
      check(vld[u] == 1'b0, "R1 valid low in reset", 64'(vld[u]), 64'h0);
    end
    rst = 1'b0;
    // First step from reset proves the default seed (R1) and the presets (R9)
    for (int u = 0; u < 2; u++) begin
      doStep(u);
      idle(u, 2);
      for (int i = 0; i < 120; i++) begin
        doStep(u);
        if (i % 9 == 0) idle(u, 1 + (i % 3));
      end
      burst(u, 12);
      idle(u, 2);
      doLoad(u, 64'h5A5A5A5, 1'b0);        // R6
      doStep(u);
      doLoad(u, 64'h0, 1'b0);              // R6 zero seed -> default
      doStep(u);
      doLoad(u, 64'h1234567, 1'b1);        // R7 load beats strobe
      idle(u, 1);
      doStep(u);
      for (int i = 0; i < 60; i++) doStep(u);  // R9 longer run per preset
    end
    // Exhaustive period walk on 7-stage register (R10 R8)
    doLoad(2, 64'h1, 1'b0);
    for (int i = 0; i < 128; i++) seen[i] = 1'b0;
    distinct = 0;
    for (int i = 1; i <= 127; i++) begin
      doStep(2);
      check(wordObs[2] != 0, "R8 zero state in period walk", wordObs[2], 64'h1);
      check(!seen[wordObs[2][6:0]], "R10 state repeated early", wordObs[2], 64'h0);
      if (!seen[wordObs[2][6:0]]) distinct++;
      seen[wordObs[2][6:0]] = 1'b1;
      if (i < 127) check(wordObs[2] != 64'h1, "R10 returned to seed early", wordObs[2], 64'h0);
      else         check(wordObs[2] == 64'h1, "R10 period end at seed", wordObs[2], 64'h1);
    end
    check(distinct == 127, "R10 all nonzero states visited", 64'(distinct), 64'd127);
  endtask

  initial begin
    fork
      runTests();
      begin
        repeat (150000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule